// File: doc/BRIEF.md
# OSD Dot Clock and Dot Size Generator

This block sets the pixel timing of one display block of an on-screen character generator. Two source ticks arrive as single-cycle enables in the system clock domain: one derived from a slicer clock and one from an oscillator. The block picks one of them and divides it by 1, 2 or 3 to get the base period TC. It counts TC periods into dots of 1 to 4 TC each and emits a one-cycle pixel-advance strobe at the end of every dot. It also counts synchronized line-sync rising edges into rows of 1 to 4 lines each, or twice that in bi-scan mode, and emits a one-cycle row-advance strobe per row.

Each line, a rising edge of the line sync restarts the horizontal machinery. The block waits the programmed start count in ticks of the selected source. It then lets one TC go by with no dot. Only after that does the first dot begin. Because of this, blocks with different sources or pre-divide ratios start at different screen positions. The configuration pins are captured only on a block-start pulse. Caption mode cannot use a ratio of 3, so the block forces it down to 2 and raises an error flag. A layer-2 block can take its ratio from the layer-1 block instead of from its own field. The block has no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `osd_dot_timing`

## Requirements
- R1: After reset, pix_stb, row_stb and cfg_err are 0, and no strobe appears until blk_start has been pulsed.
- R2: When the cfg_src_osc value captured at the last block start is 1, only osc_tick advances horizontal timing. When it is 0, only slicer_tick does.
- R3: The pre-divide code selects the TC length in selected-source ticks: 0 gives 1 tick, 1 gives 2 ticks, 2 and 3 give 3 ticks.
- R4: Count the selected-source ticks from the last restart (line-sync rise or block start) as n = 1, 2, … The start phase ends on tick hstart+1. One TC of gap follows. The first pix_stb then comes hsize TCs later, on tick n = hstart+1+ratio·(1+hsize).
- R5: A dot lasts hsize = cfg_hsize+1 TC periods. pix_stb rises in the cycle after the tick edge that ends each dot, so it is high on tick n = hstart+1+ratio·(1+hsize·j) for j ≥ 1. At all other times it is 0.
- R6: Count the line-sync rising edges since block start as L = 1, 2, … row_stb pulses exactly once for each L that is a multiple of vdiv. Here vdiv = cfg_vsize+1.
- R7: When bi-scan is captured as 1, vdiv is doubled, to 2·(cfg_vsize+1).
- R8: When caption mode is captured and the requested ratio is 3, the block uses ratio 2 and cfg_err reads 1 until the next block start. Otherwise cfg_err reads 0.
- R9: When both cfg_layer2 and cfg_share are 1, the pre-divide code is taken from ref_prediv instead of cfg_prediv. The R8 clamp is applied after this choice.
- R10: A line-sync rising edge restarts the start count, the pre-divider and the dot counter, so the R4 timing begins again.
- R11: After blk_stop, pix_stb and row_stb stay 0 whatever ticks and line-sync edges arrive.
- R12: Configuration pins changed after the blk_start pulse have no effect on timing until the next blk_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slicer_tick | input | 1 | One-cycle tick of the slicer-derived source |
| osc_tick | input | 1 | One-cycle tick of the oscillator-derived source |
| hsync_in | input | 1 | Asynchronous line-sync input |
| blk_start | input | 1 | Captures configuration, activates the block and restarts all counters |
| blk_stop | input | 1 | Deactivates the block |
| cfg_src_osc | input | 1 | Source select: 1 selects the oscillator, 0 the slicer |
| cfg_prediv | input | 2 | Pre-divide code (R3) |
| cfg_hsize | input | 2 | Dot width minus one, in TC |
| cfg_vsize | input | 2 | Dot height minus one, in lines |
| cfg_biscan | input | 1 | Doubles dot height |
| cfg_cc | input | 1 | Caption mode, forbids ratio 3 |
| cfg_layer2 | input | 1 | Block sits on the second layer |
| cfg_share | input | 1 | Layer-2 block takes its ratio from ref_prediv |
| ref_prediv | input | 2 | Pre-divide code of the first-layer block |
| cfg_hstart | input | 8 | Horizontal start count in selected-source ticks |
| pix_stb | output | 1 | One-cycle pixel-advance strobe |
| row_stb | output | 1 | One-cycle row-advance strobe |
| cfg_err | output | 1 | Illegal ratio was clamped |

## Verification
On every cycle, the assertions check the following. The pre-divider and dot counters stay within their captured limits. A pixel strobe only follows a processed source tick, and a row strobe only follows a line-sync edge. An inactive block stays silent. A caption-mode block never runs at ratio 3. Some behaviour can only be shown by the bench's scenarios. These cover the exact tick on which the first dot lands after the start count and the gap TC, and the spacing between dots. They also cover the row period with and without bi-scan, the ratio taken over from layer 1, the restart on a line-sync edge in mid-line, and the fact that configuration changes after a block start are ignored.

// File: rtl/osd_dot_pkg.sv
package osd_dot_pkg;

  localparam int CODE_W = 2;

  typedef struct packed {
    logic              src_osc;
    logic [1:0]        ratio;
    logic [CODE_W-1:0] hsz_code;
    logic [CODE_W-1:0] vsz_code;
    logic              biscan;
  } blk_cfg_t;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_GAP  = 2'd1,
    PH_RUN  = 2'd2
  } hphase_e;

  function automatic logic [1:0] code_to_ratio(input logic [1:0] code);
    logic [1:0] r;
    case (code)
      2'd0:    r = 2'd1;
      2'd1:    r = 2'd2;
      default: r = 2'd3;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/osd_hsync_sync.sv
module osd_hsync_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  output logic hs_rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], hsync_in};
  end

  assign hs_rise = shreg[LAST] & ~shreg[STAGES];

endmodule

// File: rtl/osd_cfg_latch.sv
module osd_cfg_latch
  import osd_dot_pkg::*;
#(
  parameter int HSTART_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                blk_start,
  input  logic                src_osc,
  input  logic [1:0]          prediv,
  input  logic [CODE_W-1:0]   hsize,
  input  logic [CODE_W-1:0]   vsize,
  input  logic                biscan,
  input  logic                cc_mode,
  input  logic                layer2,
  input  logic                share,
  input  logic [1:0]          ref_prediv,
  input  logic [HSTART_W-1:0] hstart,
  output blk_cfg_t            cfg_q,
  output logic [HSTART_W-1:0] hstart_q,
  output logic                cfg_err
);
  logic [1:0] sel_code;
  logic [1:0] raw_ratio;
  logic       clamp;
  blk_cfg_t   cfg_d;

  always_comb begin
    sel_code  = (layer2 && share) ? ref_prediv : prediv;
    raw_ratio = code_to_ratio(sel_code);
    clamp     = cc_mode && (raw_ratio == 2'd3);
    cfg_d.src_osc  = src_osc;
    cfg_d.ratio    = clamp ? 2'd2 : raw_ratio;
    cfg_d.hsz_code = hsize;
    cfg_d.vsz_code = vsize;
    cfg_d.biscan   = biscan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{src_osc: 1'b0, ratio: 2'd1, hsz_code: '0, vsz_code: '0, biscan: 1'b0};
      hstart_q <= '0;
      cfg_err  <= 1'b0;
    end else if (blk_start) begin
      cfg_q    <= cfg_d;
      hstart_q <= hstart;
      cfg_err  <= clamp;
    end
  end

  a_r3_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.ratio != 2'd0);

  a_r8_clamped_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (cfg_q.ratio == 2'd2));

endmodule

// File: rtl/osd_hdot_gen.sv
module osd_hdot_gen
  import osd_dot_pkg::*;
#(
  parameter int HSTART_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                restart,
  input  logic                tick,
  input  logic [1:0]          ratio,
  input  logic [CODE_W-1:0]   hsz_code,
  input  logic [HSTART_W-1:0] hstart,
  output logic                pix_stb
);
  hphase_e             phase;
  logic [HSTART_W-1:0] hcnt;
  logic [1:0]          pcnt;
  logic [CODE_W-1:0]   dcnt;
  logic                tc_end;

  assign tc_end = (pcnt == 2'(ratio - 2'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_WAIT;
      hcnt    <= '0;
      pcnt    <= '0;
      dcnt    <= '0;
      pix_stb <= 1'b0;
    end else if (restart) begin
      phase   <= PH_WAIT;
      hcnt    <= '0;
      pcnt    <= '0;
      dcnt    <= '0;
      pix_stb <= 1'b0;
    end else begin
      pix_stb <= 1'b0;
      if (active && tick) begin
        case (phase)
          PH_WAIT: begin
            if (hcnt == hstart) phase <= PH_GAP;
            else                hcnt  <= hcnt + 1'b1;
          end
          PH_GAP: begin
            if (tc_end) begin
              pcnt  <= '0;
              phase <= PH_RUN;
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
          default: begin
            if (tc_end) begin
              pcnt <= '0;
              if (dcnt == hsz_code) begin
                dcnt    <= '0;
                pix_stb <= 1'b1;
              end else begin
                dcnt <= dcnt + 1'b1;
              end
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  a_r3_prediv_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < ratio);

  a_r5_dot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt <= hsz_code);

  a_r2_pix_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |-> $past(tick && active && !restart));

  a_r4_no_pix_before_run: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_RUN) |-> !pix_stb);

endmodule

// File: rtl/osd_vdot_gen.sv
module osd_vdot_gen
  import osd_dot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              clear,
  input  logic              hs_rise,
  input  logic [CODE_W-1:0] vsz_code,
  input  logic              biscan,
  output logic              row_stb
);
  localparam int VD_W = CODE_W + 2;

  logic [VD_W-1:0] vdiv;
  logic [VD_W-1:0] vcnt;

  assign vdiv = VD_W'({1'b0, vsz_code} + 1'b1) << biscan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt    <= '0;
      row_stb <= 1'b0;
    end else if (clear) begin
      vcnt    <= '0;
      row_stb <= 1'b0;
    end else begin
      row_stb <= 1'b0;
      if (active && hs_rise) begin
        if (vcnt == vdiv - 1'b1) begin
          vcnt    <= '0;
          row_stb <= 1'b1;
        end else begin
          vcnt <= vcnt + 1'b1;
        end
      end
    end
  end

  a_r6_row_follows_rise: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |-> $past(hs_rise && active));

  a_r7_line_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt < vdiv);

endmodule

// File: rtl/osd_dot_timing.sv
module osd_dot_timing
  import osd_dot_pkg::*;
#(
  parameter int HSTART_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slicer_tick,
  input  logic                osc_tick,
  input  logic                hsync_in,
  input  logic                blk_start,
  input  logic                blk_stop,
  input  logic                cfg_src_osc,
  input  logic [1:0]          cfg_prediv,
  input  logic [1:0]          cfg_hsize,
  input  logic [1:0]          cfg_vsize,
  input  logic                cfg_biscan,
  input  logic                cfg_cc,
  input  logic                cfg_layer2,
  input  logic                cfg_share,
  input  logic [1:0]          ref_prediv,
  input  logic [HSTART_W-1:0] cfg_hstart,
  output logic                pix_stb,
  output logic                row_stb,
  output logic                cfg_err
);
  blk_cfg_t            cfg_q;
  logic [HSTART_W-1:0] hstart_q;
  logic                hs_rise;
  logic                active;
  logic                src_tick;
  logic                h_restart;

  osd_cfg_latch #(.HSTART_W(HSTART_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
    .src_osc(cfg_src_osc), .prediv(cfg_prediv), .hsize(cfg_hsize),
    .vsize(cfg_vsize), .biscan(cfg_biscan), .cc_mode(cfg_cc),
    .layer2(cfg_layer2), .share(cfg_share), .ref_prediv(ref_prediv),
    .hstart(cfg_hstart), .cfg_q(cfg_q), .hstart_q(hstart_q), .cfg_err(cfg_err)
  );

  osd_hsync_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .hs_rise(hs_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active <= 1'b0;
    else if (blk_start) active <= 1'b1;
    else if (blk_stop)  active <= 1'b0;
  end

  assign src_tick  = cfg_q.src_osc ? osc_tick : slicer_tick;
  assign h_restart = blk_start | hs_rise;

  osd_hdot_gen #(.HSTART_W(HSTART_W)) u_hdot (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(h_restart),
    .tick(src_tick), .ratio(cfg_q.ratio), .hsz_code(cfg_q.hsz_code),
    .hstart(hstart_q), .pix_stb(pix_stb)
  );

  osd_vdot_gen u_vdot (
    .clk(clk), .rst_n(rst_n), .active(active), .clear(blk_start),
    .hs_rise(hs_rise), .vsz_code(cfg_q.vsz_code), .biscan(cfg_q.biscan),
    .row_stb(row_stb)
  );

  a_r11_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!pix_stb && !row_stb));

  a_r8_err_only_caption: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !cfg_cc) |=> !cfg_err);

endmodule

// File: tb/test_osd_dot_timing.sv
`timescale 1ns/1ps
module test_osd_dot_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slicer_tick = 0, osc_tick = 0, hsync_in = 0, blk_start = 0, blk_stop = 0;
  logic cfg_src_osc = 0, cfg_biscan = 0, cfg_cc = 0, cfg_layer2 = 0, cfg_share = 0;
  logic [1:0] cfg_prediv = 0, cfg_hsize = 0, cfg_vsize = 0, ref_prediv = 0;
  logic [7:0] cfg_hstart = 0;
  logic pix_stb, row_stb, cfg_err;

  int checks = 0, failures = 0;
  int e_hstart, e_ratio, e_hsz, e_vdiv, e_src, e_err, e_act;
  int n_ticks, lines;
  bit exp_pix;

  always #2.5 clk = ~clk;

  osd_dot_timing i_osd_dot_timing (
    .clk(clk), .rst_n(rst_n), .slicer_tick(slicer_tick), .osc_tick(osc_tick),
    .hsync_in(hsync_in), .blk_start(blk_start), .blk_stop(blk_stop),
    .cfg_src_osc(cfg_src_osc), .cfg_prediv(cfg_prediv), .cfg_hsize(cfg_hsize),
    .cfg_vsize(cfg_vsize), .cfg_biscan(cfg_biscan), .cfg_cc(cfg_cc),
    .cfg_layer2(cfg_layer2), .cfg_share(cfg_share), .ref_prediv(ref_prediv),
    .cfg_hstart(cfg_hstart), .pix_stb(pix_stb), .row_stb(row_stb), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio_req(int code, int cc, int l2, int sh, int rc);
    int c, r;
    c = (l2 != 0 && sh != 0) ? rc : code;   // R9
    r = (c == 0) ? 1 : (c == 1) ? 2 : 3;    // R3
    if (cc != 0 && r == 3) r = 2;           // R8
    return r;
  endfunction

  function automatic bit pix_due(int n);
    int m;
    m = n - (e_hstart + 1) - e_ratio;       // R4 start plus one gap TC
    if (m <= 0) return 0;
    return (m % (e_ratio * e_hsz)) == 0;    // R5
  endfunction

  task automatic start_block(int src, int pd, int hs, int vs, int bi, int cc,
                             int l2, int sh, int rc, int hst);
    @(negedge clk);
    cfg_src_osc = src[0]; cfg_prediv = pd[1:0]; cfg_hsize = hs[1:0];
    cfg_vsize = vs[1:0]; cfg_biscan = bi[0]; cfg_cc = cc[0];
    cfg_layer2 = l2[0]; cfg_share = sh[0]; ref_prediv = rc[1:0];
    cfg_hstart = hst[7:0]; blk_start = 1;
    @(negedge clk);
    blk_start = 0;
    e_src = src; e_ratio = ratio_req(pd, cc, l2, sh, rc); e_hsz = hs + 1;
    e_vdiv = (vs + 1) * (bi != 0 ? 2 : 1); e_hstart = hst; e_act = 1;
    e_err = (cc != 0 && ratio_req(pd, 0, l2, sh, rc) == 3) ? 1 : 0;
    n_ticks = 0; lines = 0; exp_pix = 0;
    check(cfg_err == e_err[0], "R8 cfg_err", cfg_err, e_err);
    // R12: scramble config pins after capture
    cfg_src_osc = ~cfg_src_osc; cfg_prediv = 2'($urandom); cfg_hsize = 2'($urandom);
    cfg_vsize = 2'($urandom); cfg_biscan = ~cfg_biscan; cfg_cc = ~cfg_cc;
    cfg_hstart = 8'($urandom);
  endtask

  task automatic run_ticks(int ncyc, string tag);
    bit s, o, sel;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      check(pix_stb == exp_pix, tag, pix_stb, exp_pix);
      s = 1'($urandom % 2); o = 1'($urandom % 2);
      slicer_tick = s; osc_tick = o;
      sel = (e_src != 0) ? o : s;             // R2
      if (sel) n_ticks++;
      exp_pix = sel && e_act != 0 && pix_due(n_ticks);
    end
    @(negedge clk);
    check(pix_stb == exp_pix, tag, pix_stb, exp_pix);
    slicer_tick = 0; osc_tick = 0; exp_pix = 0;
  endtask

  task automatic line_sync(string tag);
    int rows, pixs, exp_rows;
    rows = 0; pixs = 0;
    hsync_in = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 3) hsync_in = 0;
      rows += row_stb; pixs += pix_stb;
    end
    lines++;
    exp_rows = (e_act != 0 && (lines % e_vdiv) == 0) ? 1 : 0;
    check(rows == exp_rows, tag, rows, exp_rows);
    check(pixs == 0, "R10 no pix in sync", pixs, 0);
    n_ticks = 0;                               // R10 restart
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0C1D));
    e_act = 0; e_ratio = 1; e_hsz = 1; e_vdiv = 1; e_src = 0; e_hstart = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!pix_stb && !row_stb && !cfg_err, "R1 reset state", {pix_stb, row_stb, cfg_err}, 0);
    run_ticks(40, "R1 idle before start");
    line_sync("R1 no row before start");

    // Directed: caption clamp (R8), ratio 3 from code 3 (R3)
    start_block(0, 2, 1, 0, 0, 1, 0, 0, 0, 2);
    line_sync("R6 row vdiv1"); run_ticks(120, "R8 clamped timing");
    start_block(1, 3, 0, 1, 0, 0, 0, 0, 0, 0);
    line_sync("R6 row"); run_ticks(120, "R3 code3 ratio3");
    // Layer share (R9)
    start_block(0, 2, 2, 0, 1, 0, 1, 1, 0, 5);
    line_sync("R7 biscan row"); run_ticks(150, "R9 shared ratio");
    line_sync("R7 biscan row");
    // Layer2 without share keeps own code
    start_block(1, 1, 3, 3, 0, 0, 1, 0, 2, 1);
    line_sync("R6 row"); run_ticks(150, "R9 own code");
    // Stop: nothing comes out (R11)
    @(negedge clk); blk_stop = 1; @(negedge clk); blk_stop = 0; e_act = 0;
    run_ticks(100, "R11 stopped pix");
    line_sync("R11 stopped row"); line_sync("R11 stopped row");

    // Random scenarios
    for (int sc = 0; sc < 24; sc++) begin
      start_block($urandom % 2, $urandom % 4, $urandom % 4, $urandom % 4,
                  $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                  $urandom % 4, $urandom % 20);
      line_sync("R6 row period");
      run_ticks(60 + $urandom % 120, "R4 R5 pix timing");
      line_sync("R7 row period");
      run_ticks(200, "R10 pix after restart");
      for (int k = 0; k < 6; k++) line_sync("R6 R7 row period");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule